// File: doc/BRIEF.md
# Real-time clock flags and access control

This block holds the single 8-bit status and control byte of a real-time clock. Four sticky flags record a watchdog expiry, an alarm match, a supply drop and an oscillator failure at start-up. Three control bits enable a calibration square wave on the interrupt pin, freeze the time registers for writing, and request a coherent snapshot of the running time.

The surrounding clock core reads the byte through a combinational data port, with a read strobe that consumes the event flags. It writes the byte through a write strobe. It reports writes to its time registers on a separate strobe, so that this block knows whether new time was written while the registers were frozen. When the freeze bit drops, the block issues one load pulse, and only if such a write occurred. When the snapshot bit rises, it issues one capture pulse. A free-running divider on the 32.768 kHz tick supplies the 512 Hz calibration wave.

Top module: `rtc_flagctl`

## Requirements
- R1: After reset the byte reads 0x00, `snap_capture`, `base_load` and `freeze` are low, and `int_pin` follows `irq_normal`.
- R2: Byte layout: bit 7 watchdog flag, bit 6 alarm flag, bit 5 power flag, bit 4 oscillator flag, bit 3 always reads 0, bit 2 calibration enable, bit 1 freeze (write-time), bit 0 snapshot (read-time).
- R3: A high `wdog_expire`, `alarm_hit` or `pwr_low` at a clock edge sets bit 7, 6 or 5 respectively. A set flag stays set until an edge with `reg_rd` high clears it. An event at that same edge keeps its flag set.
- R4: Write data in bits 7 to 5 and bit 3 has no effect on the byte.
- R5: `osc_fail` at an edge sets bit 4. A read does not clear bit 4, and writing 1 to it does not set it. A write with bit 4 = 0 clears it only if bit 1 was already 1 before that write. A set at the same edge wins over a clear.
- R6: Every write loads bits 2, 1 and 0 from the write data.
- R7: `snap_capture` is high for exactly the one cycle after bit 0 changes from 0 to 1.
- R8: `freeze` equals bit 1.
- R9: A `time_wr` at an edge where bit 1 is 1 marks the time as changed; a `time_wr` while bit 1 is 0 is ignored. In the cycle after bit 1 falls, `base_load` is high only if the time is marked changed, and the mark is then cleared.
- R10: A tick counter counts `tick_32k` edges modulo 64 from reset. With bit 2 set, `int_pin` is 1 when the count is 32 or more and 0 otherwise, which gives 512 Hz from a 32.768 kHz tick.
- R11: With bit 2 clear, `int_pin` equals `irq_normal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-up) |
| reg_wr | input | 1 | Write strobe for the byte |
| reg_rd | input | 1 | Read strobe; consumes flags 7 to 5 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current byte value |
| time_wr | input | 1 | A time register was written this cycle |
| wdog_expire | input | 1 | Watchdog reached zero unserviced |
| alarm_hit | input | 1 | Alarm compare matched |
| pwr_low | input | 1 | Supply below switch-over threshold |
| osc_fail | input | 1 | Oscillator not running at start-up |
| tick_32k | input | 1 | One-cycle 32.768 kHz tick enable |
| irq_normal | input | 1 | Normal interrupt level |
| snap_capture | output | 1 | Latch time into holding registers |
| base_load | output | 1 | Transfer written time into counters |
| freeze | output | 1 | Hold time register updates |
| int_pin | output | 1 | Interrupt pin level |

## Verification
The assertions take every input to be a clean synchronous level that is sampled at the rising edge. They make no assumption about how often events arrive or whether they overlap with reads and writes, so overlapping set and clear is legal. The stimulus drives all inputs on the falling edge only, so they are stable at each rising edge. It mixes directed sequences with random traffic in which events, reads, writes and tick pulses are allowed to coincide. The random traffic also covers time-register writes made while the registers are not frozen.

// File: rtl/rtc_flagctl_pkg.sv
package rtc_flagctl_pkg;
  localparam int BYTE_W = 8;
  localparam int B_WDOG = 7;
  localparam int B_ALRM = 6;
  localparam int B_PWR  = 5;
  localparam int B_OSC  = 4;
  localparam int B_CAL  = 2;
  localparam int B_FRZ  = 1;
  localparam int B_SNAP = 0;

  typedef struct packed {
    logic wdog;
    logic alrm;
    logic pwr;
    logic osc;
  } sticky_t;

  // high half of the divider period drives the square wave
  function automatic logic div_phase_high(input int unsigned cnt, input int unsigned div);
    return cnt >= (div / 2);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_byte(input sticky_t s, input logic cal,
                                                   input logic frz, input logic snap);
    logic [BYTE_W-1:0] b;
    b         = '0;
    b[B_WDOG] = s.wdog;
    b[B_ALRM] = s.alrm;
    b[B_PWR]  = s.pwr;
    b[B_OSC]  = s.osc;
    b[B_CAL]  = cal;
    b[B_FRZ]  = frz;
    b[B_SNAP] = snap;
    return b;
  endfunction
endpackage

// File: rtl/rtc_sticky_flags.sv
module rtc_sticky_flags
  import rtc_flagctl_pkg::*;
#(
  parameter int EVT_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_set,
  input  logic             rd_clr,
  input  logic             osc_set,
  input  logic             osc_clr,
  output logic [EVT_N-1:0] evt_q,
  output logic             osc_q
);
  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          evt_q[i] <= 1'b0;
      else if (evt_set[i]) evt_q[i] <= 1'b1;
      else if (rd_clr)     evt_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       osc_q <= 1'b0;
    else if (osc_set) osc_q <= 1'b1;
    else if (osc_clr) osc_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_access_ctl.sv
module rtc_access_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic cal_d,
  input  logic frz_d,
  input  logic snap_d,
  input  logic time_wr,
  output logic cal_q,
  output logic frz_q,
  output logic snap_q,
  output logic snap_rise,
  output logic frz_fall,
  output logic dirty_q,
  output logic load_pulse
);
  logic frz_prev, snap_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= 1'b0;
      frz_q  <= 1'b0;
      snap_q <= 1'b0;
    end else if (wr) begin
      cal_q  <= cal_d;
      frz_q  <= frz_d;
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_prev  <= 1'b0;
      snap_prev <= 1'b0;
    end else begin
      frz_prev  <= frz_q;
      snap_prev <= snap_q;
    end
  end

  assign snap_rise = snap_q & ~snap_prev;
  assign frz_fall  = frz_prev & ~frz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dirty_q <= 1'b0;
    else if (frz_fall)         dirty_q <= 1'b0;
    else if (time_wr && frz_q) dirty_q <= 1'b1;
  end

  assign load_pulse = frz_fall & dirty_q;
endmodule

// File: rtl/rtc_cal_div.sv
module rtc_cal_div
  import rtc_flagctl_pkg::*;
#(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic sq
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign sq = div_phase_high(32'(cnt), DIV);
endmodule

// File: rtl/rtc_flagctl.sv
module rtc_flagctl
  import rtc_flagctl_pkg::*;
#(
  parameter int CAL_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              time_wr,
  input  logic              wdog_expire,
  input  logic              alarm_hit,
  input  logic              pwr_low,
  input  logic              osc_fail,
  input  logic              tick_32k,
  input  logic              irq_normal,
  output logic              snap_capture,
  output logic              base_load,
  output logic              freeze,
  output logic              int_pin
);
  localparam int EVT_N = 3;

  logic [EVT_N-1:0] evt_q;
  logic             osc_q;
  logic             cal_q, frz_q, snap_q;
  logic             snap_rise, w_fall, dirty_q, load_pulse;
  logic             osc_clr, cal_sq;
  sticky_t          sticky;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[B_WDOG:B_PWR], reg_wdata[3]};
  assign osc_clr      = reg_wr & ~reg_wdata[B_OSC] & frz_q;

  rtc_sticky_flags #(.EVT_N(EVT_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_set ({wdog_expire, alarm_hit, pwr_low}),
    .rd_clr  (reg_rd),
    .osc_set (osc_fail),
    .osc_clr (osc_clr),
    .evt_q   (evt_q),
    .osc_q   (osc_q)
  );

  rtc_access_ctl u_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .cal_d      (reg_wdata[B_CAL]),
    .frz_d      (reg_wdata[B_FRZ]),
    .snap_d     (reg_wdata[B_SNAP]),
    .time_wr    (time_wr),
    .cal_q      (cal_q),
    .frz_q      (frz_q),
    .snap_q     (snap_q),
    .snap_rise  (snap_rise),
    .frz_fall   (w_fall),
    .dirty_q    (dirty_q),
    .load_pulse (load_pulse)
  );

  rtc_cal_div #(.DIV(CAL_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_32k),
    .sq    (cal_sq)
  );

  always_comb begin
    sticky.wdog = evt_q[2];
    sticky.alrm = evt_q[1];
    sticky.pwr  = evt_q[0];
    sticky.osc  = osc_q;
  end

  assign reg_rdata    = pack_byte(sticky, cal_q, frz_q, snap_q);
  assign snap_capture = snap_rise;
  assign base_load    = load_pulse;
  assign freeze       = frz_q;
  assign int_pin      = cal_q ? cal_sq : irq_normal;
endmodule

// File: rtl/rtc_flagctl_chk.sv
module rtc_flagctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       wdog_expire,
  input logic       snap_capture,
  input logic       base_load,
  input logic       freeze,
  input logic       w_fall,
  input logic       dirty
);
  // R3
  wdog_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire |=> reg_rdata[7]);
  // R3
  wdog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !reg_rd) |=> reg_rdata[7]);
  // R5
  osc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4] && !reg_wr) |=> reg_rdata[4]);
  // R8
  freeze_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (freeze == $past(reg_wdata[1])));
  // R7
  snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_capture |=> !snap_capture);
  // R9
  load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |-> (!freeze && $past(freeze) && w_fall));
  // R9
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |=> (!base_load && !dirty));
endmodule

bind rtc_flagctl rtc_flagctl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .wdog_expire  (wdog_expire),
  .snap_capture (snap_capture),
  .base_load    (base_load),
  .freeze       (freeze),
  .w_fall       (w_fall),
  .dirty        (dirty_q)
);

// File: tb/rtc_flagctl_tb_top.sv
module rtc_flagctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, time_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       wdog_expire = 1'b0, alarm_hit = 1'b0, pwr_low = 1'b0, osc_fail = 1'b0;
  logic       tick_32k = 1'b0, irq_normal = 1'b0;
  logic [7:0] reg_rdata;
  logic       snap_capture, base_load, freeze, int_pin;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_flagctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_wr(time_wr),
    .wdog_expire(wdog_expire), .alarm_hit(alarm_hit), .pwr_low(pwr_low),
    .osc_fail(osc_fail), .tick_32k(tick_32k), .irq_normal(irq_normal),
    .snap_capture(snap_capture), .base_load(base_load), .freeze(freeze),
    .int_pin(int_pin)
  );

  // behavioural reference
  bit     m_wdog, m_alrm, m_pwr, m_osc, m_cal, m_frz, m_snap;
  bit     m_frz_was, m_snap_was, m_changed;
  integer m_ticks = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_wdog, m_alrm, m_pwr, m_osc, m_cal, m_frz, m_snap} = '0;
      {m_frz_was, m_snap_was, m_changed} = '0;
      m_ticks = 0;
    end else begin
      bit fell;
      fell = m_frz_was && !m_frz;
      if (fell) m_changed = 0;
      else if (time_wr && m_frz) m_changed = 1;
      m_frz_was  = m_frz;
      m_snap_was = m_snap;
      if (reg_rd) begin m_wdog = 0; m_alrm = 0; m_pwr = 0; end
      if (wdog_expire) m_wdog = 1;
      if (alarm_hit)   m_alrm = 1;
      if (pwr_low)     m_pwr  = 1;
      if (osc_fail) m_osc = 1;
      else if (reg_wr && reg_wdata[4] == 0 && m_frz) m_osc = 0;
      if (reg_wr) begin
        m_cal  = reg_wdata[2];
        m_frz  = reg_wdata[1];
        m_snap = reg_wdata[0];
      end
      if (tick_32k) m_ticks = m_ticks + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit exp_int;
    exp_int = m_cal ? ((m_ticks % 64) >= 32) : irq_normal;
    chk("R3 event flags", {5'd0, reg_rdata[7:5]}, {5'd0, m_wdog, m_alrm, m_pwr});
    chk("R5 osc flag", {7'd0, reg_rdata[4]}, {7'd0, m_osc});
    chk("R2 bit3 zero", {7'd0, reg_rdata[3]}, 8'd0);
    chk("R6 control bits", {5'd0, reg_rdata[2:0]}, {5'd0, m_cal, m_frz, m_snap});
    chk("R7 snap_capture", {7'd0, snap_capture}, {7'd0, m_snap && !m_snap_was});
    chk("R8 freeze", {7'd0, freeze}, {7'd0, m_frz});
    chk("R9 base_load", {7'd0, base_load},
        {7'd0, m_frz_was && !m_frz && m_changed});
    chk(m_cal ? "R10 cal wave" : "R11 int passthrough", {7'd0, int_pin}, {7'd0, exp_int});
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; time_wr = 0;
    wdog_expire = 0; alarm_hit = 0; pwr_low = 0; osc_fail = 0; tick_32k = 0;
  endtask

  // advance one cycle: inputs for the coming edge are applied, then checked
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1 compare_all();
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); idle(); reg_wr = 1; reg_wdata = d;
    step();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    irq_normal = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 reset byte", reg_rdata, 8'h00);
    chk("R1 reset strobes", {5'd0, snap_capture, base_load, freeze}, 8'd0);
    chk("R1 reset int_pin", {7'd0, int_pin}, 8'd1);
    @(negedge clk); rst_n = 1;
    step();

    // R4 sticky bits and bit 3 not writable
    do_write(8'hE8);
    step();
    chk("R4 write ignored", reg_rdata, 8'h00);

    // R3 event then read-clear, with set winning on same edge
    @(negedge clk); wdog_expire = 1; pwr_low = 1;
    step(); idle();
    chk("R3 flags set", reg_rdata & 8'hE0, 8'hA0);
    @(negedge clk); reg_rd = 1; pwr_low = 1;
    step(); idle();
    chk("R3 read clears, set wins", reg_rdata & 8'hE0, 8'h20);

    // R5 osc flag rules
    @(negedge clk); osc_fail = 1;
    step(); idle();
    @(negedge clk); reg_rd = 1;
    step(); idle();
    chk("R5 read keeps osc", {7'd0, reg_rdata[4]}, 8'd1);
    do_write(8'h00);
    step();
    chk("R5 clear needs freeze", {7'd0, reg_rdata[4]}, 8'd1);
    do_write(8'h02);
    do_write(8'h02);
    step();
    chk("R5 clear while frozen", {7'd0, reg_rdata[4]}, 8'd0);

    // R9 unfreeze without any time write: no load
    do_write(8'h00);
    chk("R9 no load when clean", {7'd0, base_load}, 8'd0);
    // R9 freeze, write time, unfreeze: load
    do_write(8'h02);
    @(negedge clk); time_wr = 1;
    step(); idle();
    do_write(8'h00);
    chk("R9 load after change", {7'd0, base_load}, 8'd1);
    step();
    chk("R9 load one cycle", {7'd0, base_load}, 8'd0);

    // R7 snapshot
    do_write(8'h01);
    chk("R7 capture pulse", {7'd0, snap_capture}, 8'd1);
    step();
    chk("R7 capture ends", {7'd0, snap_capture}, 8'd0);

    // R10 calibration wave over two periods
    do_write(8'h04);
    for (int i = 0; i < 140; i++) begin
      @(negedge clk); tick_32k = 1;
      step();
    end
    idle();

    // random traffic
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      reg_wr      = ($urandom % 8) == 0;
      reg_wdata   = 8'($urandom);
      reg_rd      = ($urandom % 8) == 0;
      time_wr     = ($urandom % 5) == 0;
      wdog_expire = ($urandom % 25) == 0;
      alarm_hit   = ($urandom % 25) == 0;
      pwr_low     = ($urandom % 25) == 0;
      osc_fail    = ($urandom % 60) == 0;
      tick_32k    = ($urandom % 2) == 0;
      irq_normal  = ($urandom % 2) == 0;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule